// File: doc/BRIEF.md
# Write Burst to Peripheral Bus Serializer

This block sits between a memory-mapped write port in AXI4 style (address, data and response channels, each with a VALID/READY handshake) and an APB4 peripheral bus. It takes one write burst at a time and turns every beat of it into its own APB write transfer. Each transfer has a setup cycle and then one or more access cycles. The transfers are issued one after another, in the order the burst addresses them.

The peripheral can stretch any transfer by holding PREADY low, and can flag a beat as failed with PSLVERR. While a transfer is stalled, the write data channel stays back-pressured. The error indications of all beats are merged into one flag. After the last beat has completed, the burst gets exactly one write response, which reports a slave error if any beat failed. A new burst address is not accepted until that response has been taken.

Top module: `wr_burst_serializer`

## Requirements
- R1: A burst of AWLEN+1 beats produces exactly AWLEN+1 APB write transfers. With AWBURST=2'b01 (incrementing), and also for the other non-fixed codes, beat k goes to AWADDR + k*2^AWSIZE. With AWBURST=2'b00 (fixed), every beat goes to AWADDR.
- R2: Every transfer has PWRITE=1. It spends one cycle with PSEL=1 and PENABLE=0, then holds PSEL=1 and PENABLE=1 with a stable PADDR until the cycle in which PREADY is sampled high.
- R3: At most one transfer is in progress at a time. The setup cycle of a beat never comes before the PREADY completion of the previous beat.
- R4: PWDATA and PSTRB of each transfer equal the WDATA and WSTRB of the same beat. PPROT equals the AWPROT captured when the burst address was accepted.
- R5: BRESP is 2'b10 (slave error) if PSLVERR was high in the completing cycle of any beat of the burst. Otherwise BRESP is 2'b00.
- R6: Each burst gets exactly one BVALID, raised only after the final beat has completed. BVALID and BRESP hold until BREADY is seen.
- R7: WREADY is low in every cycle in which PSEL is high.
- R8: AWREADY is low from the acceptance of a burst address until its B handshake completes. Accepting a new address clears the merged error state.
- R9: Over one burst of N beats, PSEL is high for exactly 2N cycles plus the number of cycles in which PREADY was low during access.
- R10: After reset, AWREADY is high and PSEL, PENABLE, WREADY and BVALID are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| awvalid | input | 1 | Burst address valid |
| awready | output | 1 | Burst address accepted |
| awaddr | input | ADDR_W | Start address |
| awlen | input | LEN_W | Beat count minus one |
| awsize | input | 3 | Log2 of bytes per beat |
| awburst | input | 2 | Burst type |
| awprot | input | 3 | Protection attributes |
| wvalid | input | 1 | Write beat valid |
| wready | output | 1 | Write beat accepted |
| wdata | input | DATA_W | Beat data |
| wstrb | input | DATA_W/8 | Beat byte strobes |
| wlast | input | 1 | Final beat marker |
| bvalid | output | 1 | Response valid |
| bready | input | 1 | Response accepted |
| bresp | output | 2 | Burst response |
| psel | output | 1 | Peripheral select |
| penable | output | 1 | Access phase |
| paddr | output | ADDR_W | Peripheral address |
| pwrite | output | 1 | Write direction |
| pwdata | output | DATA_W | Peripheral write data |
| pstrb | output | DATA_W/8 | Peripheral byte strobes |
| pprot | output | 3 | Peripheral protection |
| pready | input | 1 | Transfer completion |
| pslverr | input | 1 | Transfer error |

## Verification
The assertions assume that the master marks WLAST on exactly the beat numbered AWLEN+1 and sends no W beats beyond the burst. They also assume that the peripheral eventually raises PREADY. The stimulus produces WLAST from the same beat count it puts on AWLEN, and it finishes the W beats before it offers another address. The bench's peripheral model draws a small, bounded number of wait cycles per beat, so every stall ends.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAITW, ST_SETUP, ST_ACCESS, ST_RESP
  } bwb_state_t;

  typedef struct packed {
    logic captureAw;
    logic captureW;
    logic stepAddr;
    logic mergeErr;
  } bwb_strobe_t;

  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/bwb_ctrl.sv
module bwb_ctrl
  import bwb_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             awvalid,
  input  logic [LEN_W-1:0] awlen,
  input  logic             wvalid,
  input  logic             wlast,
  input  logic             bready,
  input  logic             pready,
  output logic             awready,
  output logic             wready,
  output logic             bvalid,
  output logic             psel,
  output logic             penable,
  output bwb_strobe_t      strobe
);
  bwb_state_t stateQ, stateD;
  logic [LEN_W-1:0] lenQ, beatQ;
  logic lastBeat;

  assign lastBeat = (beatQ == lenQ);
  assign awready  = (stateQ == ST_IDLE);
  assign wready   = (stateQ == ST_WAITW);
  assign psel     = (stateQ == ST_SETUP) || (stateQ == ST_ACCESS);
  assign penable  = (stateQ == ST_ACCESS);
  assign bvalid   = (stateQ == ST_RESP);

  always_comb begin
    strobe.captureAw = (stateQ == ST_IDLE) && awvalid;
    strobe.captureW  = (stateQ == ST_WAITW) && wvalid;
    strobe.mergeErr  = (stateQ == ST_ACCESS) && pready;
    strobe.stepAddr  = (stateQ == ST_ACCESS) && pready && !lastBeat;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (awvalid) stateD = ST_WAITW;
      ST_WAITW:  if (wvalid) stateD = ST_SETUP;
      ST_SETUP:  stateD = ST_ACCESS;
      ST_ACCESS: if (pready) stateD = lastBeat ? ST_RESP : ST_WAITW;
      ST_RESP:   if (bready) stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      lenQ   <= '0;
      beatQ  <= '0;
    end else begin
      stateQ <= stateD;
      if (strobe.captureAw) begin
        lenQ  <= awlen;
        beatQ <= '0;
      end else if (strobe.stepAddr) begin
        beatQ <= beatQ + 1'b1;
      end
    end
  end

  // R1: the master's final-beat marker lines up with the captured length
  a_r1_wlast_final: assert property (@(posedge clk) disable iff (!rstN)
    (wvalid && wready) |-> (wlast == lastBeat));
  // R2: a setup cycle is always followed by an access cycle
  a_r2_setup_to_access: assert property (@(posedge clk) disable iff (!rstN)
    (psel && !penable) |=> (psel && penable));
  // R2: access holds while the peripheral stalls
  a_r2_hold_access: assert property (@(posedge clk) disable iff (!rstN)
    (penable && !pready) |=> (psel && penable));
  // R3: a completed beat never runs straight into another access phase
  a_r3_single_flight: assert property (@(posedge clk) disable iff (!rstN)
    (penable && pready) |=> !penable);
  // R6: response held until taken
  a_r6_b_hold: assert property (@(posedge clk) disable iff (!rstN)
    (bvalid && !bready) |=> bvalid);
  // R7: no data accepted while a transfer runs
  a_r7_wready_quiet: assert property (@(posedge clk) disable iff (!rstN)
    psel |-> !wready);
  // R8: no new address while a response is outstanding
  a_r8_aw_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (bvalid || psel) |-> !awready);
endmodule

// File: rtl/bwb_dpath.sv
module bwb_dpath
  import bwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bwb_strobe_t       strobe,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [2:0]        awsize,
  input  logic [1:0]        awburst,
  input  logic [2:0]        awprot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              pslverr,
  output logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pwdata,
  output logic [STRB_W-1:0] pstrb,
  output logic [2:0]        pprot,
  output logic              errSticky
);
  logic [2:0] sizeQ;
  logic       fixedQ;
  logic [ADDR_W-1:0] stepAmt;

  assign stepAmt = fixedQ ? '0 : (ADDR_W'(1) << sizeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paddr     <= '0;
      sizeQ     <= '0;
      fixedQ    <= 1'b0;
      pprot     <= '0;
      pwdata    <= '0;
      pstrb     <= '0;
      errSticky <= 1'b0;
    end else begin
      if (strobe.captureAw) begin
        paddr     <= awaddr;
        sizeQ     <= awsize;
        fixedQ    <= (awburst == BURST_FIXED);
        pprot     <= awprot;
        errSticky <= 1'b0;
      end else begin
        if (strobe.stepAddr) paddr <= paddr + stepAmt;
        if (strobe.mergeErr) errSticky <= errSticky | pslverr;
      end
      if (strobe.captureW) begin
        pwdata <= wdata;
        pstrb  <= wstrb;
      end
    end
  end

  // R5: once set within a burst the flag only clears on a new address
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && !strobe.captureAw) |=> errSticky);
endmodule

// File: rtl/wr_burst_serializer.sv
module wr_burst_serializer
  import bwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [LEN_W-1:0]  awlen,
  input  logic [2:0]        awsize,
  input  logic [1:0]        awburst,
  input  logic [2:0]        awprot,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wlast,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic [STRB_W-1:0] pstrb,
  output logic [2:0]        pprot,
  input  logic              pready,
  input  logic              pslverr
);
  bwb_strobe_t strobe;
  logic errSticky;

  bwb_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .awvalid(awvalid), .awlen(awlen),
    .wvalid(wvalid), .wlast(wlast), .bready(bready), .pready(pready),
    .awready(awready), .wready(wready), .bvalid(bvalid),
    .psel(psel), .penable(penable), .strobe(strobe)
  );

  bwb_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .awaddr(awaddr),
    .awsize(awsize), .awburst(awburst), .awprot(awprot),
    .wdata(wdata), .wstrb(wstrb), .pslverr(pslverr),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot),
    .errSticky(errSticky)
  );

  assign pwrite = psel;
  assign bresp  = (bvalid && errSticky) ? RESP_SLVERR : RESP_OKAY;

  // R2: address and data stay put for the whole transfer
  a_r2_paddr_stable: assert property (@(posedge clk) disable iff (!rstN)
    penable |-> ($stable(paddr) && $stable(pwdata) && $stable(pstrb)));
  // R6: response code stable while waiting
  a_r6_bresp_stable: assert property (@(posedge clk) disable iff (!rstN)
    (bvalid && !bready) |=> $stable(bresp));
endmodule

// File: tb/wr_burst_serializer_tb_top.sv
module wr_burst_serializer_tb_top;
  localparam int AW = 32, DW = 32, LW = 8, SW = DW / 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic awvalid = 0, wvalid = 0, wlast = 0, bready = 0, pready = 0, pslverr = 0;
  logic [AW-1:0] awaddr = '0;
  logic [LW-1:0] awlen = '0;
  logic [2:0] awsize = '0, awprot = '0;
  logic [1:0] awburst = '0;
  logic [DW-1:0] wdata = '0;
  logic [SW-1:0] wstrb = '0;
  logic awready, wready, bvalid, psel, penable, pwrite;
  logic [1:0] bresp;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic [SW-1:0] pstrb;
  logic [2:0] pprot;

  always #2 clk = ~clk;

  wr_burst_serializer dut_i (.*);

  int total = 0, bad = 0;
  int nBeats, idx, waitLeft, pselCycles, waitSum, wreadyBad;
  logic [AW-1:0] curBase;
  logic [2:0] curSize, curProt;
  logic [1:0] curBurst;
  logic [DW-1:0] beatData [16];
  logic [SW-1:0] beatStrb [16];
  logic errPlan [16];
  int waitPlan [16];

  function automatic logic [AW-1:0] expAddr(int k);
    if (curBurst == 2'b00) return curBase;
    return curBase + AW'(k) * (AW'(1) << curSize);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // peripheral model and transfer checks
  initial forever begin
    @(negedge clk);
    pready = 0; pslverr = 0;
    if (psel) begin
      pselCycles++;
      if (wready) wreadyBad++;
    end
    if (psel && !penable) begin
      waitLeft = waitPlan[idx];
      check("R2 pwrite", 64'(pwrite), 64'd1);
    end else if (psel && penable) begin
      if (waitLeft > 0) begin
        waitLeft--;
      end else begin
        pready = 1;
        pslverr = errPlan[idx];
        check("R1 paddr", 64'(paddr), 64'(expAddr(idx)));
        check("R4 pwdata", 64'(pwdata), 64'(beatData[idx]));
        check("R4 pstrb", 64'(pstrb), 64'(beatStrb[idx]));
        check("R4 pprot", 64'(pprot), 64'(curProt));
        idx++;
      end
    end
  end

  task automatic runBurst(int n, logic [2:0] sz, logic [1:0] bt, int errMode, int maxWait);
    logic expErr = 0;
    nBeats = n; idx = 0; pselCycles = 0; waitSum = 0; wreadyBad = 0;
    curBase = $urandom & 32'hFFFF_FFF8; curSize = sz; curBurst = bt;
    curProt = 3'($urandom);
    for (int k = 0; k < n; k++) begin
      beatData[k] = $urandom;
      beatStrb[k] = SW'($urandom);
      waitPlan[k] = (maxWait > 0) ? int'($urandom % (maxWait + 1)) : 0;
      waitSum += waitPlan[k];
      if (errMode == 0) errPlan[k] = 0;
      else if (errMode == 1) errPlan[k] = ($urandom % 4) == 0;
      else errPlan[k] = (k == 1) || (k == 3);
      expErr |= errPlan[k];
    end
    @(negedge clk);
    awvalid = 1; awaddr = curBase; awlen = LW'(n - 1); awsize = sz;
    awburst = bt; awprot = curProt;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 0;
    check("R8 awready after accept", 64'(awready), 64'd0);
    for (int k = 0; k < n; k++) begin
      repeat ($urandom % 2) @(negedge clk);
      wvalid = 1; wdata = beatData[k]; wstrb = beatStrb[k]; wlast = (k == n - 1);
      while (!wready) begin
        if (bvalid) check("R6 early bvalid", 64'(bvalid), 64'd0);
        @(negedge clk);
      end
      @(negedge clk);
      wvalid = 0; wlast = 0;
    end
    while (!bvalid) @(negedge clk);
    check("R1 beat count", 64'(idx), 64'(n));
    check("R5 bresp", 64'(bresp), expErr ? 64'd2 : 64'd0);
    repeat ($urandom % 3) begin
      @(negedge clk);
      check("R6 bvalid held", 64'(bvalid), 64'd1);
      check("R8 awready blocked", 64'(awready), 64'd0);
    end
    bready = 1;
    @(negedge clk);
    bready = 0;
    check("R6 single response", 64'(bvalid), 64'd0);
    check("R8 awready back", 64'(awready), 64'd1);
    check("R9 psel cycles", 64'(pselCycles), 64'(2 * n + waitSum));
    check("R7 wready during transfer", 64'(wreadyBad), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R10 awready", 64'(awready), 64'd1);
    check("R10 psel", 64'(psel), 64'd0);
    check("R10 penable", 64'(penable), 64'd0);
    check("R10 wready", 64'(wready), 64'd0);
    check("R10 bvalid", 64'(bvalid), 64'd0);
    runBurst(4, 3'd2, 2'b01, 2, 0);   // R5 beats 2 and 4 fail -> one slave error
    runBurst(1, 3'd2, 2'b01, 0, 0);   // R8 flag cleared -> OKAY
    runBurst(5, 3'd1, 2'b00, 0, 3);   // R1 fixed address with waits
    runBurst(8, 3'd0, 2'b01, 1, 2);
    for (int i = 0; i < 30; i++)
      runBurst(1 + int'($urandom % 8), 3'($urandom % 3), 2'($urandom % 2), 1, 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule